// File: doc/BRIEF.md
# Condition Code And Branch Unit

This unit keeps the three sign flags of a 16-bit processor core and decides where the program counter goes next. It watches the register write-back port. When an instruction that is allowed to set the flags writes a register, the unit records whether the written value was negative, zero or positive. Flags change on the clock edge after the write and affect branch decisions from the next cycle on.

For the instruction being executed, the unit works out the next PC combinationally. The inputs are the current instruction word, the incremented PC and the value of the jump base register, which the datapath reads from the register file. A conditional branch tests any subset of the flags chosen by its mask and adds a sign-extended offset when the test passes. A register jump always redirects to the base value. A trap raises a request and puts out the zero-extended vector as the address of the trap-table entry. Reading that entry and any later redirect are left to the surrounding core.

The reset input is asserted asynchronously and released through a two-stage synchronizer inside the unit.

Top module: `ccbr_unit`

## Requirements
- R1: Once reset is applied, the flags read {N,Z,P} = 3'b010 and stay at that value until a qualifying write-back.
- R2: When `wb_en` is high and `wb_op` is one of 0001, 0101, 1001, 0010, 0110, 1010 or 1110, the flags after the next rising edge are N when `wb_value[15]` is 1, Z when `wb_value` is zero, and P otherwise.
- R3: A write-back with `wb_en` low, or with any other opcode, leaves the flags unchanged.
- R4: For a branch (instruction bits [15:12] = 0000), `taken` is high exactly when mask bit 11 is set with N, bit 10 with Z, or bit 9 with P. The test uses the flags held before any write-back in the same cycle.
- R5: A taken branch gives `next_pc` = `pc_inc` + the sign extension of instruction bits [8:0], modulo 2^16. A branch that is not taken gives `next_pc` = `pc_inc`.
- R6: A branch with mask 000 is never taken. A branch with mask 111 is always taken.
- R7: For a register jump (bits [15:12] = 1100), `taken` is high and `next_pc` equals `base_val`.
- R8: For a trap (bits [15:12] = 1111 with bits [11:8] = 0000), `trap_req` is high, `trap_addr` is bits [7:0] zero-extended to 16 bits, `taken` is low and `next_pc` equals `pc_inc`.
- R9: Any other instruction, including a trap pattern with nonzero bits [11:8], gives `taken` low, `trap_req` low, `trap_addr` zero and `next_pc` equal to `pc_inc`.
- R10: Exactly one flag is set at all times out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wb_en | input | 1 | Register write-back strobe |
| wb_op | input | 4 | Opcode of the instruction that produced the write-back |
| wb_value | input | 16 | Value being written to the register file |
| instr | input | 16 | Instruction word being resolved |
| pc_inc | input | 16 | Address of the instruction after the current one |
| base_val | input | 16 | Contents of the register named by instruction bits [8:6] |
| flags | output | 3 | Held flags as {N,Z,P} |
| taken | output | 1 | PC redirect for branch or jump |
| next_pc | output | 16 | PC for the next fetch |
| trap_req | output | 1 | Trap entry requested |
| trap_addr | output | 16 | Trap-table entry address |

## Verification
A wrong flag state does not change `taken` in the cycle it is written. It shows up on the `flags` port one edge after the write-back. It shows up on `taken` for the first branch that follows, whose mask includes either the flag that should be set or the one that was set wrongly. For this reason the bench follows every flag-setting write with a sweep of all eight masks. It also places a branch in the same cycle as a write-back, to catch flags being forwarded too early. Target arithmetic errors show up at once on `next_pc`, so offsets are chosen to cover both signs and wrap-around at both ends of the address space.

// File: rtl/ccbr_pkg.sv
package ccbr_pkg;

  localparam logic [3:0] OPC_BR   = 4'b0000;
  localparam logic [3:0] OPC_ADD  = 4'b0001;
  localparam logic [3:0] OPC_LD   = 4'b0010;
  localparam logic [3:0] OPC_AND  = 4'b0101;
  localparam logic [3:0] OPC_LDR  = 4'b0110;
  localparam logic [3:0] OPC_NOT  = 4'b1001;
  localparam logic [3:0] OPC_LDI  = 4'b1010;
  localparam logic [3:0] OPC_JMP  = 4'b1100;
  localparam logic [3:0] OPC_LEA  = 4'b1110;
  localparam logic [3:0] OPC_TRAP = 4'b1111;

  typedef struct packed {
    logic n;
    logic z;
    logic p;
  } cc_t;

  localparam cc_t CC_RESET = '{n: 1'b0, z: 1'b1, p: 1'b0};

  // opcodes whose register result also refreshes the sign flags
  function automatic logic cc_writer(input logic [3:0] op);
    case (op)
      OPC_ADD, OPC_AND, OPC_NOT, OPC_LD, OPC_LDR, OPC_LDI, OPC_LEA: cc_writer = 1'b1;
      default: cc_writer = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ccbr_rst_sync.sv
module ccbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/ccbr_flags.sv
module ccbr_flags
  import ccbr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_en,
  input  logic [3:0]        wb_op,
  input  logic [DATA_W-1:0] wb_value,
  output cc_t               flags_q
);

  logic upd_en;
  cc_t  cls_d;

  always_comb begin
    upd_en   = wb_en & cc_writer(wb_op);
    cls_d.n  = wb_value[DATA_W-1];
    cls_d.z  = (wb_value == '0);
    cls_d.p  = ~wb_value[DATA_W-1] & (wb_value != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= CC_RESET;
    else if (upd_en) flags_q <= cls_d;
  end

  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flags_q) == 1); // R10

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_en && cc_writer(wb_op)) |=> $stable(flags_q)); // R3

  AST_FLAGS_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && cc_writer(wb_op) && wb_value[DATA_W-1]) |=> flags_q.n); // R2

  AST_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && cc_writer(wb_op) && wb_value == '0) |=> flags_q.z); // R2

endmodule

// File: rtl/ccbr_resolve.sv
module ccbr_resolve
  import ccbr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 9,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] pc_inc,
  input  logic [DATA_W-1:0] base_val,
  input  cc_t               flags,
  output logic              taken,
  output logic [DATA_W-1:0] next_pc,
  output logic              trap_req,
  output logic [DATA_W-1:0] trap_addr
);

  localparam int OPC_LSB = DATA_W - 4;
  localparam int MSK_LSB = OPC_LSB - 3;

  logic [3:0]        opc;
  logic [2:0]        mask;
  logic [DATA_W-1:0] br_ofs;
  logic              cond_hit;
  logic              trap_ok;

  always_comb begin
    opc      = instr[DATA_W-1:OPC_LSB];
    mask     = instr[OPC_LSB-1:MSK_LSB];
    br_ofs   = {{(DATA_W-OFF_W){instr[OFF_W-1]}}, instr[OFF_W-1:0]};
    cond_hit = |(mask & {flags.n, flags.z, flags.p});
    trap_ok  = (instr[OPC_LSB-1:VEC_W] == '0);
  end

  always_comb begin
    taken     = 1'b0;
    next_pc   = pc_inc;
    trap_req  = 1'b0;
    trap_addr = '0;
    case (opc)
      OPC_BR: begin
        taken = cond_hit;
        if (cond_hit) next_pc = pc_inc + br_ofs;
      end
      OPC_JMP: begin
        taken   = 1'b1;
        next_pc = base_val;
      end
      OPC_TRAP: begin
        if (trap_ok) begin
          trap_req  = 1'b1;
          trap_addr = {{(DATA_W-VEC_W){1'b0}}, instr[VEC_W-1:0]};
        end
      end
      default: ;
    endcase
  end

  AST_NULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[DATA_W-1:OPC_LSB] == OPC_BR && instr[OPC_LSB-1:MSK_LSB] == 3'b000) |-> !taken); // R6

  AST_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[DATA_W-1:OPC_LSB] == OPC_BR && instr[OPC_LSB-1:MSK_LSB] == 3'b111) |-> taken); // R6

  AST_JMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[DATA_W-1:OPC_LSB] == OPC_JMP) |-> (taken && next_pc == base_val)); // R7

  AST_TRAP_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (!taken && next_pc == pc_inc)); // R8

  AST_QUIET_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[DATA_W-1:OPC_LSB] != OPC_BR && instr[DATA_W-1:OPC_LSB] != OPC_JMP
     && instr[DATA_W-1:OPC_LSB] != OPC_TRAP) |-> (!taken && !trap_req && next_pc == pc_inc)); // R9

endmodule

// File: rtl/ccbr_unit.sv
module ccbr_unit
  import ccbr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 9,
  parameter int VEC_W  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_en,
  input  logic [3:0]        wb_op,
  input  logic [DATA_W-1:0] wb_value,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] pc_inc,
  input  logic [DATA_W-1:0] base_val,
  output logic [2:0]        flags,
  output logic              taken,
  output logic [DATA_W-1:0] next_pc,
  output logic              trap_req,
  output logic [DATA_W-1:0] trap_addr
);

  logic rst_n_sync;
  cc_t  cc_q;

  ccbr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  ccbr_flags #(.DATA_W(DATA_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .wb_en    (wb_en),
    .wb_op    (wb_op),
    .wb_value (wb_value),
    .flags_q  (cc_q)
  );

  ccbr_resolve #(.DATA_W(DATA_W), .OFF_W(OFF_W), .VEC_W(VEC_W)) u_resolve (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .instr     (instr),
    .pc_inc    (pc_inc),
    .base_val  (base_val),
    .flags     (cc_q),
    .taken     (taken),
    .next_pc   (next_pc),
    .trap_req  (trap_req),
    .trap_addr (trap_addr)
  );

  assign flags = {cc_q.n, cc_q.z, cc_q.p};

endmodule

// File: tb/ccbr_unit_tb.sv
`timescale 1ns/1ps
module ccbr_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        wb_en;
  logic [3:0]  wb_op;
  logic [15:0] wb_value;
  logic [15:0] instr;
  logic [15:0] pc_inc;
  logic [15:0] base_val;
  logic [2:0]  flags;
  logic        taken;
  logic [15:0] next_pc;
  logic        trap_req;
  logic [15:0] trap_addr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int mflags;   // model flags: 4 = N, 2 = Z, 1 = P

  ccbr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wb_en(wb_en), .wb_op(wb_op), .wb_value(wb_value),
    .instr(instr), .pc_inc(pc_inc), .base_val(base_val), .flags(flags),
    .taken(taken), .next_pc(next_pc), .trap_req(trap_req), .trap_addr(trap_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit qualifies(input int op);
    case (op)
      1, 5, 9, 2, 6, 10, 14: qualifies = 1'b1;
      default:               qualifies = 1'b0;
    endcase
  endfunction

  function automatic int classify(input int v);
    if (v[15])      classify = 4;
    else if (v == 0) classify = 2;
    else             classify = 1;
  endfunction

  task automatic step(input int ins, input int pc, input int base,
                      input bit wen, input int wop, input int wval,
                      input string otag, input string ftag);
    int op, msk, off, e_tk, e_np, e_tr, e_ta;
    @(negedge clk);
    instr = ins[15:0]; pc_inc = pc[15:0]; base_val = base[15:0];
    wb_en = wen; wb_op = wop[3:0]; wb_value = wval[15:0];
    op = (ins >> 12) & 15;
    e_tk = 0; e_np = pc & 16'hFFFF; e_tr = 0; e_ta = 0;
    if (op == 0) begin
      msk = (ins >> 9) & 7;
      if ((msk & mflags) != 0) begin
        e_tk = 1;
        off = ins & 511;
        if (off >= 256) off = off - 512;
        e_np = (pc + off) & 16'hFFFF;
      end
    end else if (op == 12) begin
      e_tk = 1; e_np = base & 16'hFFFF;
    end else if (op == 15 && ((ins >> 8) & 15) == 0) begin
      e_tr = 1; e_ta = ins & 255;
    end
    #1;
    chk(otag, "taken", int'(taken), e_tk);
    chk(otag, "next_pc", int'(next_pc), e_np);
    chk(otag, "trap_req", int'(trap_req), e_tr);
    chk(otag, "trap_addr", int'(trap_addr), e_ta);
    @(posedge clk);
    if (wen && qualifies(wop)) mflags = classify(wval);
    #1;
    chk(ftag, "flags", int'(flags), mflags);
    chk("R10", "flag count", $countones(flags), 1);
  endtask

  task automatic sweep_masks(input int pc);
    for (int m = 0; m < 8; m++) begin
      int off;
      off = (m * 73 + 300) & 511;
      step((m << 9) | off, pc, 0, 0, 0, 0, (m == 0 || m == 7) ? "R6" : "R5", "R3");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wb_en = 0; wb_op = 0; wb_value = 0;
    instr = 16'h1000; pc_inc = 16'h0100; base_val = 0;
    mflags = 2;
    repeat (3) @(posedge clk);
    #1 chk("R1", "flags in reset", int'(flags), 2);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R1", "flags after release", int'(flags), 2);

    // R4: only Z is set after reset
    step(16'h0405, 16'h2000, 0, 0, 0, 0, "R4", "R1");
    step(16'h0A05, 16'h2000, 0, 0, 0, 0, "R4", "R1");

    // R2: each qualifying opcode, then all eight masks
    step(16'h1000, 16'h3000, 0, 1, 1,  16'h8000, "R9", "R2"); sweep_masks(16'h3000);
    step(16'h1000, 16'h3000, 0, 1, 5,  16'h0000, "R9", "R2"); sweep_masks(16'h3010);
    step(16'h1000, 16'h3000, 0, 1, 14, 16'h0005, "R9", "R2"); sweep_masks(16'h3020);
    step(16'h1000, 16'h3000, 0, 1, 6,  16'hFFFF, "R9", "R2"); sweep_masks(16'h3030);
    step(16'h1000, 16'h3000, 0, 1, 10, 16'h7FFF, "R9", "R2"); sweep_masks(16'h3040);
    step(16'h1000, 16'h3000, 0, 1, 9,  16'h0000, "R9", "R2"); sweep_masks(16'h3050);
    step(16'h1000, 16'h3000, 0, 1, 2,  16'h1234, "R9", "R2"); sweep_masks(16'h3060);

    // R4: a branch in the same cycle as a write uses the old flags (P held)
    step(16'h0810, 16'h4000, 0, 1, 1, 16'h8000, "R4", "R2");
    step(16'h0810, 16'h4000, 0, 0, 0, 0, "R4", "R3");
    step(16'h0210, 16'h4000, 0, 0, 0, 0, "R4", "R3");

    // R3: non-qualifying writes leave N in place
    step(16'h1000, 16'h4000, 0, 1, 3,  16'h0000, "R9", "R3");
    step(16'h1000, 16'h4000, 0, 1, 0,  16'h0005, "R9", "R3");
    step(16'h1000, 16'h4000, 0, 1, 12, 16'h0005, "R9", "R3");
    step(16'h1000, 16'h4000, 0, 1, 15, 16'h0000, "R9", "R3");
    step(16'h1000, 16'h4000, 0, 1, 7,  16'h0001, "R9", "R3");
    step(16'h1000, 16'h4000, 0, 0, 1,  16'h0000, "R9", "R3");
    step(16'h0800, 16'h4000, 0, 0, 0, 0, "R3", "R3");

    // R5: wrap-around at both ends
    step(16'h0FFF, 16'h0000, 0, 0, 0, 0, "R5", "R3");
    step(16'h0EFF, 16'hFFFF, 0, 0, 0, 0, "R5", "R3");
    step(16'h0F00, 16'h0080, 0, 0, 0, 0, "R5", "R3");

    // R7: register jump
    step(16'hC0C0, 16'h5000, 16'hABCD, 0, 0, 0, "R7", "R3");
    step(16'hC1C0, 16'h5000, 16'h0000, 0, 0, 0, "R7", "R3");

    // R8: trap entry
    step(16'hF025, 16'h6000, 0, 0, 0, 0, "R8", "R3");
    step(16'hF0FF, 16'h6000, 0, 0, 0, 0, "R8", "R3");
    step(16'hF000, 16'h6000, 0, 0, 0, 0, "R8", "R3");

    // R9: malformed trap and other opcodes
    step(16'hF125, 16'h6000, 0, 0, 0, 0, "R9", "R3");
    step(16'hF825, 16'h6000, 0, 0, 0, 0, "R9", "R3");
    step(16'h1234, 16'h7000, 16'h1111, 0, 0, 0, "R9", "R3");
    step(16'h8000, 16'h7000, 0, 0, 0, 0, "R9", "R3");
    step(16'h4800, 16'h7000, 16'h2222, 0, 0, 0, "R9", "R3");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule